// File: doc/BRIEF.md
# Slow-Bank Tag Directory Filter

This block is a small set-associative tag store placed next to a fast cache bank. It records the tag of every line that currently lives in one paired slow, dense bank, and nothing else. Each request that reaches the fast bank is presented to the directory in the same cycle. One cycle later the directory either forwards the request to the slow bank, together with the way that holds the line, or drops it, so that the slow bank is never touched for a line it does not hold.

The slow bank reports every fill through the allocate port and every removal through the deallocate port. The directory keeps an exact copy of the slow bank's tags and answers each operation one cycle later with a done or error flag and the way used. Within one cycle the three operations take effect in a fixed order: deallocate first, then allocate, then lookup. A lookup therefore sees the changes made by operations issued in the same cycle. The geometry (sets, ways, line size, address width) is set by parameters. The defaults are 16 sets, 4 ways, 64-byte lines and 32-bit byte addresses, so tag = addr[31:10] and set = addr[9:6].

Top module: `tdir_filter`

## Requirements
- R1: After reset every entry is invalid, all response outputs are low, and the first lookup of any address is dropped.
- R2: A request address splits into byte offset addr[5:0] (ignored), set index addr[9:6] and tag addr[31:10]. Allocate and deallocate take a line address {tag, set} whose low 4 bits are the set.
- R3: A request whose tag is valid in its set gives fwd_valid=1 with fwd_addr equal to the request address and fwd_way equal to the way that holds the tag. Any other request gives drop_valid=1 and fwd_valid=0. The two flags are never high together.
- R4: The result of a lookup appears exactly one cycle after req_valid. In a cycle that follows no request, both fwd_valid and drop_valid are low.
- R5: An allocate into a set with a free way and no copy of the tag writes the tag into the lowest-numbered invalid way. One cycle later alloc_ok=1 and alloc_way names that way. Without alloc_valid, alloc_ok and alloc_err stay low.
- R6: An allocate into a set whose ways are all valid raises alloc_err one cycle later and changes no entry.
- R7: An allocate of a tag already valid in its set raises alloc_err and changes no entry.
- R8: A deallocate of a present tag invalidates its way. One cycle later dealloc_ok=1 with dealloc_way. Later lookups of that line are dropped, and the way is free for the next allocate.
- R9: A deallocate of a tag not present in its set raises dealloc_err one cycle later and changes no entry.
- R10: Operations issued in the same cycle apply as deallocate, then allocate, then lookup. A lookup sees a same-cycle allocate or deallocate, and an allocate may reuse a way freed in the same cycle.
- R11: Operations on one set leave the contents of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| fwd_valid | output | 1 | Previous request hit; send it to the slow bank |
| drop_valid | output | 1 | Previous request missed; discard it |
| fwd_way | output | WAY_W | Way holding the hit line |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| alloc_valid | input | 1 | Slow bank adds a line |
| alloc_line | input | ADDR_W-OFF_W | Line address of the added line |
| alloc_ok | output | 1 | Allocate accepted |
| alloc_err | output | 1 | Allocate rejected (set full or duplicate) |
| alloc_way | output | WAY_W | Way written by an accepted allocate |
| dealloc_valid | input | 1 | Slow bank removes a line |
| dealloc_line | input | ADDR_W-OFF_W | Line address of the removed line |
| dealloc_ok | output | 1 | Deallocate found and cleared the tag |
| dealloc_err | output | 1 | Deallocate named an absent tag |
| dealloc_way | output | WAY_W | Way cleared by the deallocate |

## Verification
The assertions assume that reset is held for at least one clock edge before any operation. They also assume that the valid and address inputs are always driven to known values, because the one-cycle response properties tie each output flag to the valid input of the previous edge. The properties place no limit on how the three operations combine, so the stimulus mixes lookups, allocates and deallocates freely. This includes all three in one cycle and on the same set, as well as allocates into full sets and deallocates of absent tags. All inputs change only at the falling clock edge, which keeps them stable around every sampling edge.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

    // Status of an allocate or deallocate as held for one cycle.
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_DONE = 2'd1,
        OUT_FAIL = 2'd2
    } outcome_e;

endpackage

// File: rtl/tdir_match.sv
// Compares one set's row of tags against a key and reports which ways
// hold it and which ways are free.
module tdir_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22
) (
    input  logic [WAYS-1:0]            row_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hit,
    output logic [WAYS-1:0]            free
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w]  = row_vld[w] && (row_tag[w] == key);
        assign free[w] = !row_vld[w];
    end
endmodule

// File: rtl/tdir_pick.sv
// Lowest-index priority encoder.
module tdir_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tdir_filter.sv
module tdir_filter
    import tdir_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    fwd_valid,
    output logic                    drop_valid,
    output logic [WAY_W-1:0]        fwd_way,
    output logic [ADDR_W-1:0]       fwd_addr,
    input  logic                    alloc_valid,
    input  logic [ADDR_W-OFF_W-1:0] alloc_line,
    output logic                    alloc_ok,
    output logic                    alloc_err,
    output logic [WAY_W-1:0]        alloc_way,
    input  logic                    dealloc_valid,
    input  logic [ADDR_W-OFF_W-1:0] dealloc_line,
    output logic                    dealloc_ok,
    output logic                    dealloc_err,
    output logic [WAY_W-1:0]        dealloc_way
);
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    typedef logic [SETS-1:0][WAYS-1:0]            vld_arr_t;
    typedef logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_arr_t;

    typedef struct packed {
        vld_arr_t           vld;
        tag_arr_t           tag;
        logic               lk_hit;
        logic               lk_miss;
        logic [WAY_W-1:0]   lk_way;
        logic [ADDR_W-1:0]  lk_addr;
        outcome_e           al_st;
        logic [WAY_W-1:0]   al_way;
        outcome_e           de_st;
        logic [WAY_W-1:0]   de_way;
    } state_t;

    state_t state_q, state_d;

    // Address fields
    logic [IDX_W-1:0] d_set, a_set, l_set;
    logic [TAG_W-1:0] d_tag, a_tag, l_tag;
    logic [LINE_W-1:0] l_line;

    assign l_line = req_addr[ADDR_W-1:OFF_W];
    assign d_set  = dealloc_line[IDX_W-1:0];
    assign d_tag  = dealloc_line[LINE_W-1:IDX_W];
    assign a_set  = alloc_line[IDX_W-1:0];
    assign a_tag  = alloc_line[LINE_W-1:IDX_W];
    assign l_set  = l_line[IDX_W-1:0];
    assign l_tag  = l_line[LINE_W-1:IDX_W];

    // Stage 1: deallocate against the registered state
    logic [WAYS-1:0]            d_row_vld, d_hit, d_free_unused;
    logic [WAYS-1:0][TAG_W-1:0] d_row_tag;
    logic                       d_any;
    logic [WAY_W-1:0]           d_idx;
    vld_arr_t                   vld_1;

    assign d_row_vld = state_q.vld[d_set];
    assign d_row_tag = state_q.tag[d_set];

    tdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_dea (
        .row_vld(d_row_vld), .row_tag(d_row_tag), .key(d_tag),
        .hit(d_hit), .free(d_free_unused)
    );
    tdir_pick #(.N(WAYS), .IW(WAY_W)) u_pick_dea (
        .vec(d_hit), .any(d_any), .idx(d_idx)
    );

    always_comb begin
        vld_1 = state_q.vld;
        if (dealloc_valid && d_any) vld_1[d_set][d_idx] = 1'b0;
    end

    // Stage 2: allocate against the state after the deallocate
    logic [WAYS-1:0]            a_row_vld, a_hit, a_free;
    logic [WAYS-1:0][TAG_W-1:0] a_row_tag;
    logic                       a_dup_any, a_free_any, a_take;
    logic [WAY_W-1:0]           a_dup_idx, a_idx;
    vld_arr_t                   vld_2;
    tag_arr_t                   tag_2;

    assign a_row_vld = vld_1[a_set];
    assign a_row_tag = state_q.tag[a_set];

    tdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_alc (
        .row_vld(a_row_vld), .row_tag(a_row_tag), .key(a_tag),
        .hit(a_hit), .free(a_free)
    );
    tdir_pick #(.N(WAYS), .IW(WAY_W)) u_pick_dup (
        .vec(a_hit), .any(a_dup_any), .idx(a_dup_idx)
    );
    tdir_pick #(.N(WAYS), .IW(WAY_W)) u_pick_free (
        .vec(a_free), .any(a_free_any), .idx(a_idx)
    );

    assign a_take = alloc_valid && a_free_any && !a_dup_any;

    always_comb begin
        vld_2 = vld_1;
        tag_2 = state_q.tag;
        if (a_take) begin
            vld_2[a_set][a_idx] = 1'b1;
            tag_2[a_set][a_idx] = a_tag;
        end
    end

    // Stage 3: lookup against the state after both updates
    logic [WAYS-1:0]            l_row_vld, l_hit, l_free_unused;
    logic [WAYS-1:0][TAG_W-1:0] l_row_tag;
    logic                       l_any;
    logic [WAY_W-1:0]           l_idx;

    assign l_row_vld = vld_2[l_set];
    assign l_row_tag = tag_2[l_set];

    tdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_lkp (
        .row_vld(l_row_vld), .row_tag(l_row_tag), .key(l_tag),
        .hit(l_hit), .free(l_free_unused)
    );
    tdir_pick #(.N(WAYS), .IW(WAY_W)) u_pick_lkp (
        .vec(l_hit), .any(l_any), .idx(l_idx)
    );

    // Next-state assembly
    always_comb begin
        state_d         = state_q;
        state_d.vld     = vld_2;
        state_d.tag     = tag_2;
        state_d.lk_hit  = req_valid && l_any;
        state_d.lk_miss = req_valid && !l_any;
        state_d.lk_way  = l_any ? l_idx : '0;
        state_d.lk_addr = req_valid ? req_addr : '0;
        state_d.al_st   = !alloc_valid ? OUT_IDLE : (a_take ? OUT_DONE : OUT_FAIL);
        state_d.al_way  = a_take ? a_idx : '0;
        state_d.de_st   = !dealloc_valid ? OUT_IDLE : (d_any ? OUT_DONE : OUT_FAIL);
        state_d.de_way  = (dealloc_valid && d_any) ? d_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign fwd_valid   = state_q.lk_hit;
    assign drop_valid  = state_q.lk_miss;
    assign fwd_way     = state_q.lk_way;
    assign fwd_addr    = state_q.lk_addr;
    assign alloc_ok    = (state_q.al_st == OUT_DONE);
    assign alloc_err   = (state_q.al_st == OUT_FAIL);
    assign alloc_way   = state_q.al_way;
    assign dealloc_ok  = (state_q.de_st == OUT_DONE);
    assign dealloc_err = (state_q.de_st == OUT_FAIL);
    assign dealloc_way = state_q.de_way;

    // a_dup_idx is needed only for its any flag; fold it into nothing else.
    logic unused_ok;
    assign unused_ok = &{1'b0, a_dup_idx, d_free_unused, l_free_unused};
endmodule

// File: rtl/tdir_filter_chk.sv
module tdir_filter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              fwd_valid,
    input logic              drop_valid,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic              alloc_valid,
    input logic              alloc_ok,
    input logic              alloc_err,
    input logic              dealloc_valid,
    input logic              dealloc_ok,
    input logic              dealloc_err
);
    a_r3_fwd_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && drop_valid));

    a_r3_fwd_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!fwd_valid || fwd_addr == $past(req_addr)));

    a_r4_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fwd_valid || drop_valid));

    a_r4_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(fwd_valid || drop_valid));

    a_r5_alloc_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> (alloc_ok != alloc_err));

    a_r5_alloc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_valid |=> !(alloc_ok || alloc_err));

    a_r8_dealloc_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_valid |=> (dealloc_ok != dealloc_err));

    a_r9_dealloc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dealloc_valid |=> !(dealloc_ok || dealloc_err));
endmodule

bind tdir_filter tdir_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .fwd_valid(fwd_valid), .drop_valid(drop_valid), .fwd_addr(fwd_addr),
    .alloc_valid(alloc_valid), .alloc_ok(alloc_ok), .alloc_err(alloc_err),
    .dealloc_valid(dealloc_valid), .dealloc_ok(dealloc_ok), .dealloc_err(dealloc_err)
);

// File: tb/tdir_filter_test.sv
module tdir_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 16;
    localparam int NWAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        fwd_valid, drop_valid;
    logic [1:0]  fwd_way;
    logic [31:0] fwd_addr;
    logic        alloc_valid = 1'b0;
    logic [25:0] alloc_line = '0;
    logic        alloc_ok, alloc_err;
    logic [1:0]  alloc_way;
    logic        dealloc_valid = 1'b0;
    logic [25:0] dealloc_line = '0;
    logic        dealloc_ok, dealloc_err;
    logic [1:0]  dealloc_way;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdir_filter uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .fwd_valid(fwd_valid), .drop_valid(drop_valid), .fwd_way(fwd_way), .fwd_addr(fwd_addr),
        .alloc_valid(alloc_valid), .alloc_line(alloc_line),
        .alloc_ok(alloc_ok), .alloc_err(alloc_err), .alloc_way(alloc_way),
        .dealloc_valid(dealloc_valid), .dealloc_line(dealloc_line),
        .dealloc_ok(dealloc_ok), .dealloc_err(dealloc_err), .dealloc_way(dealloc_way)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          fwd, drop;
        logic [1:0]  fway;
        logic [31:0] faddr;
        bit          aok, aerr;
        logic [1:0]  away;
        bit          dok, derr;
        logic [1:0]  dway;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // Behavioural contents model
    bit          mv [NSETS][NWAYS];
    logic [21:0] mt [NSETS][NWAYS];

    function automatic logic [25:0] ln(input logic [21:0] t, input logic [3:0] s);
        return {t, s};
    endfunction

    function automatic logic [31:0] ad(input logic [21:0] t, input logic [3:0] s, input logic [5:0] o);
        return {t, s, o};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Driver: applies one cycle of inputs and queues the expected response.
    task automatic step(input bit rv, input logic [31:0] ra,
                        input bit av, input logic [25:0] al,
                        input bit dv, input logic [25:0] dl, input string req);
        exp_t e;
        int   s, hitw, freew;
        @(negedge clk);
        req_valid = rv; req_addr = ra;
        alloc_valid = av; alloc_line = al;
        dealloc_valid = dv; dealloc_line = dl;
        e = '{fwd: 0, drop: 0, fway: 0, faddr: 0, aok: 0, aerr: 0, away: 0,
              dok: 0, derr: 0, dway: 0, req: req};
        if (dv) begin
            s = int'(dl[3:0]); hitw = -1;
            for (int w = 0; w < NWAYS; w++) if (mv[s][w] && mt[s][w] == dl[25:4]) hitw = w;
            if (hitw >= 0) begin mv[s][hitw] = 0; e.dok = 1; e.dway = 2'(hitw); end
            else e.derr = 1;
        end
        if (av) begin
            s = int'(al[3:0]); hitw = -1; freew = -1;
            for (int w = 0; w < NWAYS; w++) if (mv[s][w] && mt[s][w] == al[25:4]) hitw = w;
            for (int w = NWAYS - 1; w >= 0; w--) if (!mv[s][w]) freew = w;
            if (hitw < 0 && freew >= 0) begin
                mv[s][freew] = 1; mt[s][freew] = al[25:4]; e.aok = 1; e.away = 2'(freew);
            end else e.aerr = 1;
        end
        if (rv) begin
            s = int'(ra[9:6]); hitw = -1;
            for (int w = 0; w < NWAYS; w++) if (mv[s][w] && mt[s][w] == ra[31:10]) hitw = w;
            if (hitw >= 0) begin e.fwd = 1; e.fway = 2'(hitw); e.faddr = ra; end
            else e.drop = 1;
        end
        exp_q.push_back(e);
    endtask

    task automatic idle(input string req);
        step(0, '0, 0, '0, 0, '0, req);
    endtask

    task automatic look(input logic [31:0] a, input string req);
        step(1, a, 0, '0, 0, '0, req);
    endtask

    task automatic alc(input logic [25:0] l, input string req);
        step(0, '0, 1, l, 0, '0, req);
    endtask

    task automatic dea(input logic [25:0] l, input string req);
        step(0, '0, 0, '0, 1, l, req);
    endtask

    // Monitor: compares each cycle's outputs with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "fwd_valid", 32'(fwd_valid), 32'(e.fwd));
                chk(e.req, "drop_valid", 32'(drop_valid), 32'(e.drop));
                if (e.fwd) begin
                    chk(e.req, "fwd_way", 32'(fwd_way), 32'(e.fway));
                    chk(e.req, "fwd_addr", fwd_addr, e.faddr);
                end
                chk(e.req, "alloc_ok", 32'(alloc_ok), 32'(e.aok));
                chk(e.req, "alloc_err", 32'(alloc_err), 32'(e.aerr));
                if (e.aok) chk(e.req, "alloc_way", 32'(alloc_way), 32'(e.away));
                chk(e.req, "dealloc_ok", 32'(dealloc_ok), 32'(e.dok));
                chk(e.req, "dealloc_err", 32'(dealloc_err), 32'(e.derr));
                if (e.dok) chk(e.req, "dealloc_way", 32'(dealloc_way), 32'(e.dway));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) begin mv[s][w] = 0; mt[s][w] = '0; end

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state of all outputs
        chk("R1", "fwd_valid", 32'(fwd_valid), 0);
        chk("R1", "drop_valid", 32'(drop_valid), 0);
        chk("R1", "alloc_ok|err", 32'(alloc_ok | alloc_err), 0);
        chk("R1", "dealloc_ok|err", 32'(dealloc_ok | dealloc_err), 0);
        @(negedge clk);
        rst_n = 1'b1;

        look(ad(22'h11, 4'd3, 6'd0), "R1");        // empty directory drops
        idle("R4");
        alc(ln(22'h11, 4'd3), "R5");               // way 0
        look(ad(22'h11, 4'd3, 6'h2a), "R2");       // offset ignored, hit way 0
        look(ad(22'h11, 4'd4, 6'd0), "R11");       // other set misses
        alc(ln(22'h12, 4'd3), "R5");
        alc(ln(22'h13, 4'd3), "R5");
        alc(ln(22'h14, 4'd3), "R5");               // set 3 full
        alc(ln(22'h15, 4'd3), "R6");               // rejected
        look(ad(22'h15, 4'd3, 6'd1), "R6");        // not stored
        look(ad(22'h14, 4'd3, 6'd2), "R6");        // older tags intact
        alc(ln(22'h12, 4'd3), "R7");               // duplicate
        dea(ln(22'h12, 4'd3), "R8");               // frees way 1
        look(ad(22'h12, 4'd3, 6'd0), "R8");
        alc(ln(22'h12, 4'd3), "R7");               // now allowed again in way 1
        look(ad(22'h12, 4'd3, 6'd9), "R3");
        dea(ln(22'h33, 4'd3), "R9");               // absent
        look(ad(22'h13, 4'd3, 6'd0), "R9");
        // R10: all three in one cycle on set 3; alloc reuses freed way, lookup sees it
        step(1, ad(22'h20, 4'd3, 6'd4), 1, ln(22'h20, 4'd3), 1, ln(22'h13, 4'd3), "R10");
        // R10: lookup of a line deallocated in the same cycle is dropped
        step(1, ad(22'h11, 4'd3, 6'd0), 0, '0, 1, ln(22'h11, 4'd3), "R10");
        alc(ln(22'h11, 4'd5), "R11");              // set 5 independent
        look(ad(22'h14, 4'd3, 6'd0), "R11");
        idle("R4");

        for (int i = 0; i < 400; i++) begin
            step(1'($urandom_range(0, 1)), ad(22'($urandom_range(1, 6)), 4'($urandom_range(0, 3)), 6'($urandom_range(0, 63))),
                 1'($urandom_range(0, 1)), ln(22'($urandom_range(1, 6)), 4'($urandom_range(0, 3))),
                 1'($urandom_range(0, 3) == 0), ln(22'($urandom_range(1, 6)), 4'($urandom_range(0, 3))),
                 "R11");
        end

        // Contents sweep: every (tag, set) pair of the random range
        for (int s = 0; s < 6; s++)
            for (int t = 1; t <= 6; t++) look(ad(22'(t), 4'(s), 6'd0), "R3");

        idle("R4");
        idle("R4");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule